// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the thirty-two 32-bit data entries of a geometry coprocessor. A processor core uses a single move-to port to write one entry per clock and a single move-from port to read any entry combinationally. Direct loads and stores into the coprocessor use the same ports, so they follow the same rules.

Most entries behave like ordinary storage, but some do more. Some indices sign-extend or zero-extend their low halfword when read. One index pushes into a three-deep queue of screen coordinates. A pair of indices converts between a packed 15-bit colour word and three separate 5-bit channel entries. Another pair loads a count of leading sign bits when a value is written. Writes to three indices are dropped.

Top module: `gcp_data_regs`

## Requirements
- R1: While `rst` is high at a rising edge, every entry is cleared to zero. After reset, a read of any index returns 0.
- R2: A read of index 1, 3, 5, 8, 9, 10 or 11 returns stored bits 15:0 sign-extended to 32 bits.
- R3: A read of index 7, 16, 17, 18 or 19 returns stored bits 15:0 zero-extended to 32 bits.
- R4: A write to index 15 shifts the coordinate queue: entry 12 takes the old entry 13, entry 13 takes the old entry 14, and entry 14 takes the written value. A read of index 15 returns entry 14.
- R5: A write to index 28 stores the raw value in entry 28. Value bits 4:0, 9:5 and 14:10 go to bits 11:7 of entries 9, 10 and 11 respectively, and all other bits of those entries are cleared.
- R6: A read of index 29 returns bits 11:7 of entries 9, 10 and 11 in result bits 4:0, 9:5 and 14:10, with all other bits zero. An entry whose bit 15 is set contributes zero.
- R7: A write to index 30 stores the value and loads entry 31 with the number of leading bits equal to the sign bit, counted after inverting a negative value. Both 0 and all-ones give 32.
- R8: Writes to index 7, 29 or 31 change no entry.
- R9: A read of index 28 or 30 returns 0. Every index not named in R2 to R7 reads back exactly what was stored.
- R10: A write becomes visible on the move-from port right after the rising edge that captures it. Reads follow `rd_idx` with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Move-to strobe |
| wr_idx | input | 5 | Move-to entry index |
| wr_data | input | 32 | Move-to value |
| rd_idx | input | 5 | Move-from entry index |
| rd_data | output | 32 | Move-from value, formatted per index |

## Verification
The bench builds the block with its package defaults: a 5-bit index, which gives the full 32-entry space, and 32-bit words. At these values it can write every index with several patterns and read back all 32 indices after each write, comparing each read with a shadow model. The colour channel width of 5 bits means all 32768 packed colour words can be swept through the split-then-pack path. The 32-bit word means every one-hot and one-cold value can be driven through the leading-bit counter.

// File: rtl/gcp_regs_pkg.sv
package gcp_regs_pkg;

    localparam int DW      = 32;
    localparam int IDX_W   = 5;
    localparam int NREGS   = 1 << IDX_W;
    localparam int HALF_W  = DW / 2;
    localparam int CH_W    = 5;
    localparam int N_CH    = 3;
    localparam int CH_LSB  = 7;
    localparam int CLS_W   = $clog2(DW + 1);

    typedef logic [DW-1:0]    word_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [CH_W-1:0]  chan_t;

    // one colour channel as seen by the packer: its blocking bit and field
    typedef struct packed {
        logic  blocked;
        chan_t field;
    } chan_src_t;

    localparam idx_t IX_HALF_RO = idx_t'(7);
    localparam idx_t IX_CH0     = idx_t'(9);
    localparam idx_t IX_Q_OLD   = idx_t'(12);
    localparam idx_t IX_Q_MID   = idx_t'(13);
    localparam idx_t IX_Q_NEW   = idx_t'(14);
    localparam idx_t IX_Q_PUSH  = idx_t'(15);
    localparam idx_t IX_COL_IN  = idx_t'(28);
    localparam idx_t IX_COL_OUT = idx_t'(29);
    localparam idx_t IX_SGN_IN  = idx_t'(30);
    localparam idx_t IX_SGN_CNT = idx_t'(31);

    typedef enum logic [2:0] {
        RK_RAW,
        RK_SEXT,
        RK_ZEXT,
        RK_QTOP,
        RK_PACK,
        RK_ZERO
    } rd_kind_e;

    typedef enum logic [2:0] {
        WK_PLAIN,
        WK_DROP,
        WK_QPUSH,
        WK_SPLIT,
        WK_SIGNCNT
    } wr_kind_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    function automatic rd_kind_e read_kind(input idx_t i);
        case (i)
            idx_t'(1), idx_t'(3), idx_t'(5), idx_t'(8),
            idx_t'(9), idx_t'(10), idx_t'(11):              return RK_SEXT;
            idx_t'(7), idx_t'(16), idx_t'(17), idx_t'(18),
            idx_t'(19):                                     return RK_ZEXT;
            IX_Q_PUSH:                                      return RK_QTOP;
            IX_COL_OUT:                                     return RK_PACK;
            IX_COL_IN, IX_SGN_IN:                           return RK_ZERO;
            default:                                        return RK_RAW;
        endcase
    endfunction

    function automatic wr_kind_e write_kind(input idx_t i);
        case (i)
            IX_HALF_RO, IX_COL_OUT, IX_SGN_CNT: return WK_DROP;
            IX_Q_PUSH:                          return WK_QPUSH;
            IX_COL_IN:                          return WK_SPLIT;
            IX_SGN_IN:                          return WK_SIGNCNT;
            default:                            return WK_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/gcp_sign_count.sv
module gcp_sign_count
    import gcp_regs_pkg::*;
(
    input  word_t              val,
    output logic [CLS_W-1:0]   cnt
);
    word_t mag;

    always_comb begin
        mag = val[DW-1] ? ~val : val;
        cnt = CLS_W'(DW);
        for (int b = 0; b < DW; b++) begin
            if (mag[b]) cnt = CLS_W'(DW - 1 - b);
        end
    end

    // R7
    always_comb begin
        if (!$isunknown(val)) begin
            if (int'(cnt) < DW) begin
                lead_bit_pos_chk: assert ((mag >> (DW - 1 - int'(cnt))) == word_t'(1));
            end else begin
                lead_all_sign_chk: assert (mag == '0);
            end
        end
    end

endmodule

// File: rtl/gcp_colour_conv.sv
module gcp_colour_conv
    import gcp_regs_pkg::*;
(
    input  logic [N_CH*CH_W-1:0] split_src,
    output word_t                split_out [N_CH],
    input  chan_src_t            pack_src  [N_CH],
    output word_t                packed_out
);
    logic [N_CH*CH_W-1:0] pack_bits;

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        always_comb begin
            split_out[k] = '0;
            split_out[k][CH_LSB +: CH_W] = split_src[k*CH_W +: CH_W];
        end
        assign pack_bits[k*CH_W +: CH_W] =
            pack_src[k].blocked ? chan_t'(0) : pack_src[k].field;
    end

    assign packed_out = word_t'(pack_bits);

endmodule

// File: rtl/gcp_read_fmt.sv
module gcp_read_fmt
    import gcp_regs_pkg::*;
(
    input  rd_kind_e kind,
    input  word_t    raw,
    input  word_t    queue_top,
    input  word_t    packed_col,
    output word_t    value
);
    always_comb begin
        case (kind)
            RK_SEXT: value = {{(DW-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            RK_ZEXT: value = {{(DW-HALF_W){1'b0}}, raw[HALF_W-1:0]};
            RK_QTOP: value = queue_top;
            RK_PACK: value = packed_col;
            RK_ZERO: value = '0;
            default: value = raw;
        endcase
    end

endmodule

// File: rtl/gcp_data_regs.sv
module gcp_data_regs
    import gcp_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DW-1:0]        rd_data
);
    word_t       rf [NREGS];
    wr_req_t     req;
    wr_kind_e    wkind;
    rd_kind_e    rkind;
    logic [CLS_W-1:0] sign_cnt;
    word_t       split_w [N_CH];
    chan_src_t   ch_src  [N_CH];
    word_t       packed_w;

    assign req   = '{en: wr_en, idx: wr_idx, data: wr_data};
    assign wkind = write_kind(req.idx);
    assign rkind = read_kind(rd_idx);

    gcp_sign_count u_cnt (
        .val (req.data),
        .cnt (sign_cnt)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_src
        assign ch_src[k] = '{blocked: rf[int'(IX_CH0) + k][HALF_W-1],
                             field:   rf[int'(IX_CH0) + k][CH_LSB +: CH_W]};
    end

    gcp_colour_conv u_col (
        .split_src  (req.data[N_CH*CH_W-1:0]),
        .split_out  (split_w),
        .pack_src   (ch_src),
        .packed_out (packed_w)
    );

    gcp_read_fmt u_rd (
        .kind       (rkind),
        .raw        (rf[rd_idx]),
        .queue_top  (rf[IX_Q_NEW]),
        .packed_col (packed_w),
        .value      (rd_data)
    );

    for (genvar e = 0; e < NREGS; e++) begin : g_ent
        localparam idx_t ME = idx_t'(e);
        logic  upd;
        word_t nxt;

        always_comb begin
            upd = 1'b0;
            nxt = rf[e];
            case (wkind)
                WK_PLAIN: begin
                    if (req.idx == ME) begin upd = 1'b1; nxt = req.data; end
                end
                WK_QPUSH: begin
                    if (ME == IX_Q_OLD) begin upd = 1'b1; nxt = rf[IX_Q_MID]; end
                    if (ME == IX_Q_MID) begin upd = 1'b1; nxt = rf[IX_Q_NEW]; end
                    if (ME == IX_Q_NEW) begin upd = 1'b1; nxt = req.data;     end
                end
                WK_SPLIT: begin
                    if (ME == IX_COL_IN) begin upd = 1'b1; nxt = req.data; end
                    for (int k = 0; k < N_CH; k++) begin
                        if (int'(ME) == int'(IX_CH0) + k) begin
                            upd = 1'b1;
                            nxt = split_w[k];
                        end
                    end
                end
                WK_SIGNCNT: begin
                    if (ME == IX_SGN_IN)  begin upd = 1'b1; nxt = req.data;        end
                    if (ME == IX_SGN_CNT) begin upd = 1'b1; nxt = word_t'(sign_cnt); end
                end
                default: ;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)                 rf[e] <= '0;
            else if (req.en && upd)  rf[e] <= nxt;
        end
    end

    logic any_set;
    always_comb begin
        any_set = 1'b0;
        for (int e = 0; e < NREGS; e++) any_set = any_set | (|rf[e]);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !any_set);

    // R4
    queue_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_Q_PUSH) |=>
            (rf[IX_Q_NEW] == $past(wr_data)) && (rf[IX_Q_MID] == $past(rf[IX_Q_NEW]))
            && (rf[IX_Q_OLD] == $past(rf[IX_Q_MID])));

    // R5
    colour_split_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_COL_IN) |=>
            (rf[IX_CH0][CH_LSB-1:0] == '0) && (rf[IX_CH0][DW-1:CH_LSB+CH_W] == '0)
            && (rf[IX_CH0][CH_LSB +: CH_W] == $past(wr_data[CH_W-1:0]))
            && (rf[IX_COL_IN] == $past(wr_data)));

    // R7
    sign_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_SGN_IN) |=>
            (rf[IX_SGN_CNT] >= word_t'(1)) && (rf[IX_SGN_CNT] <= word_t'(DW)));

    // R8
    drop_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == IX_HALF_RO || wr_idx == IX_COL_OUT || wr_idx == IX_SGN_CNT)) |=>
            (rf[IX_HALF_RO] == $past(rf[IX_HALF_RO])) && (rf[IX_COL_OUT] == $past(rf[IX_COL_OUT]))
            && (rf[IX_SGN_CNT] == $past(rf[IX_SGN_CNT])));

endmodule

// File: tb/sim_gcp_data_regs.sv
`timescale 1ns/1ps
module sim_gcp_data_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] m [32];

    always #2 clk = ~clk;

    gcp_data_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [31:0] lead_ref(input logic [31:0] v);
        logic [31:0] x;
        int n;
        bit stop;
        x = v[31] ? ~v : v;
        n = 0;
        stop = 0;
        for (int b = 31; b >= 0; b--) begin
            if (!stop) begin
                if (x[b]) stop = 1; else n++;
            end
        end
        return 32'(n);
    endfunction

    function automatic logic [4:0] chan_ref(input logic [31:0] r);
        return r[15] ? 5'd0 : r[11:7];
    endfunction

    function automatic logic [31:0] model_read(input int i);
        case (i)
            1, 3, 5, 8, 9, 10, 11: return {{16{m[i][15]}}, m[i][15:0]};
            7, 16, 17, 18, 19:     return {16'h0, m[i][15:0]};
            15:                    return m[14];
            29:                    return {17'h0, chan_ref(m[11]), chan_ref(m[10]), chan_ref(m[9])};
            28, 30:                return 32'h0;
            default:               return m[i];
        endcase
    endfunction

    function automatic string rd_tag(input int i);
        case (i)
            1, 3, 5, 8, 9, 10, 11: return "R2";
            7, 16, 17, 18, 19:     return "R3";
            15:                    return "R4";
            29:                    return "R6";
            default:               return "R9";
        endcase
    endfunction

    function automatic string wr_tag(input int i);
        case (i)
            15:        return "R4";
            28:        return "R5";
            30:        return "R7";
            7, 29, 31: return "R8";
            default:   return "R10";
        endcase
    endfunction

    task automatic model_write(input int i, input logic [31:0] v);
        case (i)
            7, 29, 31: ;
            15: begin m[12] = m[13]; m[13] = m[14]; m[14] = v; end
            28: begin
                m[28] = v;
                m[9]  = {20'h0, v[4:0],   7'h0};
                m[10] = {20'h0, v[9:5],   7'h0};
                m[11] = {20'h0, v[14:10], 7'h0};
            end
            30: begin m[30] = v; m[31] = lead_ref(v); end
            default: m[i] = v;
        endcase
    endtask

    task automatic do_write(input int i, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(i); wr_data = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(i, v);
    endtask

    task automatic check_rd(input int i, input string tag);
        logic [31:0] exp;
        rd_idx = 5'(i);
        #0.5;
        exp = model_read(i);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_idx=%0d actual=%08h expected=%08h", tag, i, rd_data, exp);
        end
    endtask

    task automatic check_all(input string wtag);
        for (int i = 0; i < 32; i++) check_rd(i, {wtag, "/", rd_tag(i)});
    endtask

    initial begin
        logic [31:0] pats [4];
        logic [31:0] lf;
        pats[0] = 32'h0000_8001; pats[1] = 32'hFFFF_7FFE;
        pats[2] = 32'h1234_5678; pats[3] = 32'hA5A5_C3C3;
        for (int i = 0; i < 32; i++) m[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: every index reads zero after reset
        for (int i = 0; i < 32; i++) check_rd(i, "R1");

        // full write-index by read-index sweep (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 32; w++) begin
                do_write(w, pats[p] ^ (32'(w) * 32'h0101_0101));
                check_all(wr_tag(w));
            end
        end

        // R6: bit 15 of a channel entry blocks it
        do_write(9,  32'h0000_8F80);
        do_write(10, 32'h0000_0F80);
        do_write(11, 32'h0000_8000);
        check_rd(29, "R6");

        // R5 R6: every packed colour word through split then pack
        for (int v = 0; v < 32768; v++) begin
            do_write(28, 32'(v) | 32'hFFFF_8000);
            check_rd(29, "R5");
        end

        // R7: one-hot and one-cold values, plus both extremes
        for (int k = 0; k < 32; k++) begin
            do_write(30, 32'h1 << k);
            check_rd(31, "R7");
            do_write(30, ~(32'h1 << k));
            check_rd(31, "R7");
        end
        do_write(30, 32'h0);
        check_rd(31, "R7");
        do_write(30, 32'hFFFF_FFFF);
        check_rd(31, "R7");
        lf = 32'hACE1_1234;
        for (int n = 0; n < 64; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_write(30, lf >> (n % 32));
            check_rd(31, "R7");
            check_rd(30, "R9");
        end

        // R1: reset again clears everything written above
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 32; i++) m[i] = '0;
        for (int i = 0; i < 32; i++) check_rd(i, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule